// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches a calendar that is kept elsewhere and decides, once per second, whether an alarm event has occurred. The calendar supplies six BCD fields (seconds, minutes, hours, day of month, month and a three-digit year) together with a one-cycle strobe that marks each one-second advance. Software programs six alarm values and a control word through a simple write port. The control word holds one compare enable per field and a global enable.

The alarm events of the enabled fields are combined by OR. On a strobe cycle with the global enable set, the block sets a sticky status flag if any enabled alarm field equals its calendar field. That flag is presented directly as a level interrupt. Software clears the flag by writing a one to bit 1 of the status address. Written alarm values are trimmed to the width each BCD field can actually use. The month is compared in the same 1-based BCD form that software sees.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset `alarmIrq` is low, the control word is zero and every alarm field holds zero.
- R2: Control bit 6 is the global enable; while it is 0 a strobe never sets the flag, whatever the field matches.
- R3: Control bits 0..5 enable the compare of seconds, minutes, hours, day, month and year in that order; a matching field whose bit is 0 does not fire.
- R4: On a strobe with bit 6 set, the flag is set if at least one enabled field matches (OR, not AND); if no enabled field matches, it stays clear.
- R5: Compares happen only on a cycle with `secTick` high; `alarmIrq` goes high at the clock edge that samples that strobe and never without one.
- R6: Written alarm values are masked: seconds and minutes keep bits 6:0, hours and day keep bits 5:0, month keeps bits 4:0, year keeps bits 11:0 of `wrData`.
- R7: The year is compared as a 12-bit BCD value, with tens and units in bits 7:0 and hundreds in bits 11:8; a hundreds mismatch means no match.
- R8: A write to address 7 with `wrData[1]`=1 clears the flag and `alarmIrq`; a write there with bit 1 = 0, or a write to any other address, leaves it unchanged.
- R9: Once set, the flag holds through later strobes that do not match, until it is cleared.
- R10: If a firing strobe and a clearing write fall in the same cycle, the flag ends up set.
- R11: The write address map is 0 = control (bits 6:0), 1 = seconds, 2 = minutes, 3 = hours, 4 = day, 5 = month, 6 = year, 7 = status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| secTick | input | 1 | One-cycle strobe after each calendar second advance |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDay | input | 8 | Current day of month, BCD |
| curMon | input | 8 | Current month, 1-based BCD |
| curYear | input | 12 | Current year, three BCD digits |
| alarmIrq | output | 1 | Level alarm interrupt (the status flag) |

## Verification
The comparator is tried with one enabled field matching alone, with several fields enabled where only one matches, with all fields enabled and none matching, and with a matching field left disabled. Together these separate OR combining from AND combining and show that the per-field enables are honoured. The global enable is varied with the same matching inputs. Writes carry junk in the high bits to show that the masks are applied. A year that differs only in its hundreds digit shows the full 12-bit compare. Directed cases cover stickiness across later strobes, clearing writes with the correct and wrong bit, and a clear that collides with a firing strobe.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int GLOBAL_BIT = 6;
  localparam int STAT_BIT   = 1;
  localparam int CTRL_W     = 7;

  typedef enum logic [2:0] {
    ADR_CTRL = 3'd0,
    ADR_SEC  = 3'd1,
    ADR_MIN  = 3'd2,
    ADR_HOUR = 3'd3,
    ADR_DAY  = 3'd4,
    ADR_MON  = 3'd5,
    ADR_YEAR = 3'd6,
    ADR_STAT = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldLoad;
  } dpStrb_t;

  // usable bit count of each alarm field, index 0 = seconds .. 5 = year
  function automatic int fieldBits(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int YEAR_W = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrb_t                            strb,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic [NUM_FIELDS-1:0][YEAR_W-1:0]  curVal,
  output logic [NUM_FIELDS-1:0]              matchVec
);
  logic [NUM_FIELDS-1:0][YEAR_W-1:0] almQ;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [YEAR_W-1:0] FIELD_MASK = YEAR_W'((64'd1 << fieldBits(i)) - 64'd1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        almQ[i] <= '0;
      end else if (strb.fieldLoad[i]) begin
        almQ[i] <= wrData[YEAR_W-1:0] & FIELD_MASK;
      end
    end

    assign matchVec[i] = (almQ[i] == curVal[i]);
  end

  // R11
  onehot_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.fieldLoad));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  secTick,
  input  logic [NUM_FIELDS-1:0] matchVec,
  output dpStrb_t               strb,
  output logic                  statusQ
);
  logic [CTRL_W-1:0] ctrlQ;
  logic              ctrlWr;
  logic              clrReq;
  logic              fire;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(ADR_CTRL));
  assign clrReq = wrEn && (wrAddr == ADDR_W'(ADR_STAT)) && wrData[STAT_BIT];
  assign fire   = secTick && ctrlQ[GLOBAL_BIT] &&
                  (|(matchVec & ctrlQ[NUM_FIELDS-1:0]));

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign strb.fieldLoad[i] = wrEn && (wrAddr == ADDR_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= 1'b0;
    end else if (fire) begin
      statusQ <= 1'b1;
    end else if (clrReq) begin
      statusQ <= 1'b0;
    end
  end

  // R2
  global_off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[GLOBAL_BIT] && !statusQ) |=> !statusQ);
  // R5
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> $past(secTick));
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !secTick) |=> !statusQ);
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !(wrEn && wrAddr == ADDR_W'(ADR_STAT))) |=> statusQ);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && ctrlQ[GLOBAL_BIT] && matchVec[0] && ctrlQ[0]) |=> statusQ);
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import alarm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int FIELD_W = 8,
  parameter int YEAR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               secTick,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curDay,
  input  logic [FIELD_W-1:0] curMon,
  input  logic [YEAR_W-1:0]  curYear,
  output logic               alarmIrq
);
  dpStrb_t                           strb;
  logic [NUM_FIELDS-1:0]             matchVec;
  logic [NUM_FIELDS-1:0][YEAR_W-1:0] curVal;

  assign curVal[0] = YEAR_W'(curSec);
  assign curVal[1] = YEAR_W'(curMin);
  assign curVal[2] = YEAR_W'(curHour);
  assign curVal[3] = YEAR_W'(curDay);
  assign curVal[4] = YEAR_W'(curMon);
  assign curVal[5] = curYear;

  alarm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .secTick(secTick), .matchVec(matchVec), .strb(strb), .statusQ(alarmIrq)
  );

  alarm_dp #(.DATA_W(DATA_W), .YEAR_W(YEAR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curVal(curVal), .matchVec(matchVec)
  );
endmodule

// File: tb/bcd_alarm_match_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_match_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        secTick = 1'b0;
  logic [7:0]  curSec = '0, curMin = '0, curHour = '0, curDay = '0, curMon = '0;
  logic [11:0] curYear = '0;
  logic        alarmIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  bcd_alarm_match dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .secTick(secTick), .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curMon(curMon), .curYear(curYear), .alarmIrq(alarmIrq)
  );

  // ctrl[111:105] aSec aMin aHour aDay aMon (8 each) aYear[64:53]
  // cSec cMin cHour cDay cMon (8 each) cYear[12:1] exp[0]
  localparam int NV = 15;
  localparam logic [111:0] VECS [NV] = '{
    // R4: all enabled, none match
    {7'h7F, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b0},
    // R4: seconds alone matches
    {7'h41, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b1},
    // R2: global enable off
    {7'h01, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b0},
    // R3: seconds match but its enable off
    {7'h7E, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b0},
    // R3: hours bit 2
    {7'h44, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 12'h199, 1'b1},
    // R3: month bit 4, 1-based
    {7'h50, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 12'h199, 1'b1},
    // R7: year full match
    {7'h60, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h205, 1'b1},
    // R7: only hundreds differ
    {7'h60, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h105, 1'b0},
    // R6: seconds written 0xB0 -> 0x30
    {7'h41, 8'hB0, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b1},
    // R6: minutes written 0x95 -> 0x15
    {7'h42, 8'h30, 8'h95, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h15, 8'h00, 8'h01, 8'h01, 12'h199, 1'b1},
    // R6: hours written 0xC8 -> 0x08
    {7'h44, 8'h30, 8'h15, 8'hC8, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 12'h199, 1'b1},
    // R6: day written 0xD2 -> 0x12
    {7'h48, 8'h30, 8'h15, 8'h08, 8'hD2, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 12'h199, 1'b1},
    // R6: month written 0xE6 -> 0x06
    {7'h50, 8'h30, 8'h15, 8'h08, 8'h12, 8'hE6, 12'h205, 8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 12'h199, 1'b1},
    // R4: seconds off by one
    {7'h41, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h31, 8'h00, 8'h00, 8'h01, 8'h01, 12'h199, 1'b0},
    // R4: all enabled, only day matches (OR)
    {7'h7F, 8'h30, 8'h15, 8'h08, 8'h12, 8'h06, 12'h205, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 12'h199, 1'b1}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: alarmIrq=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setCur(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] mo, input logic [11:0] y);
    curSec = s; curMin = m; curHour = h; curDay = d; curMon = mo; curYear = y;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, alarmIrq=%0b expected completion", alarmIrq);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset irq low", alarmIrq, 1'b0);
    // R1: zeroed alarm seconds must match current seconds 00 once enabled
    setCur(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
    wr(3'd0, 16'h0041);
    tick();
    check("R1 reset alarm fields zero", alarmIrq, 1'b1);
    wr(3'd7, 16'h0002);
    check("R8 clear after reset test", alarmIrq, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [111:0] vec;
      vec = VECS[v];
      wr(3'd0, 16'h0000);
      wr(3'd1, {8'h00, vec[104:97]});
      wr(3'd2, {8'h00, vec[96:89]});
      wr(3'd3, {8'h00, vec[88:81]});
      wr(3'd4, {8'h00, vec[80:73]});
      wr(3'd5, {8'h00, vec[72:65]});
      wr(3'd6, {4'h0, vec[64:53]});
      wr(3'd0, {9'h000, vec[111:105]});
      wr(3'd7, 16'h0002);
      setCur(vec[52:45], vec[44:37], vec[36:29], vec[28:21], vec[20:13], vec[12:1]);
      repeat (2) @(negedge clk);
      check($sformatf("R5 no fire before tick, vector %0d", v), alarmIrq, 1'b0);
      tick();
      check($sformatf("R4 R3 R6 R7 vector %0d", v), alarmIrq, vec[0]);
      wr(3'd7, 16'h0002);
    end

    // R6: year mask drops bits 15:12
    wr(3'd6, 16'hF205);
    wr(3'd0, 16'h0060);
    setCur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h205);
    tick();
    check("R6 year masked to 12 bits", alarmIrq, 1'b1);

    // R9: sticky across non-matching strobes
    setCur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h206);
    tick();
    tick();
    check("R9 sticky after non-matching ticks", alarmIrq, 1'b1);

    // R8: wrong bit and other address leave flag set
    wr(3'd7, 16'hFFFD);
    check("R8 write bit1=0 keeps flag", alarmIrq, 1'b1);
    wr(3'd1, 16'h0002);
    check("R8 other address keeps flag", alarmIrq, 1'b1);
    wr(3'd7, 16'h0002);
    check("R8 w1c clears flag", alarmIrq, 1'b0);

    // R5: a match held for many cycles without a strobe does not fire
    setCur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h205);
    repeat (10) @(negedge clk);
    check("R5 match without tick", alarmIrq, 1'b0);

    // R10: clear and firing strobe in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd7; wrData = 16'h0002; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    check("R10 set wins over clear", alarmIrq, 1'b1);

    // R2: disabling the global bit, then a matching strobe after clear
    wr(3'd0, 16'h0020);
    wr(3'd7, 16'h0002);
    tick();
    check("R2 global off no fire", alarmIrq, 1'b0);

    // R11: year lives at address 6, seconds write does not affect it
    wr(3'd1, 16'h0205);
    wr(3'd0, 16'h0060);
    setCur(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h205);
    tick();
    check("R11 year address independent of seconds", alarmIrq, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule